// File: doc/BRIEF.md
# FM Bit-Cell Line Encoder and Decoder

This block converts a serial bit stream to a frequency-modulated line waveform and back. Every bit cell lasts 4 µs (250 kbit/s). The line changes level at the start of every cell. A logic 0 adds a second change halfway through the cell. A logic 1 has no change in the middle of the cell. The whole block runs on a single 4 MHz sample clock, which gives 16 samples per cell. The transmitter derives its bit strobe (250 kHz) and its half-cell strobe (500 kHz) from that clock.

The transmitter pulses `tx_cell_start` in the cycle where it samples `tx_data`. The receiver does three things:

- It passes the incoming line through a two-stage synchroniser and detects level changes.
- It keeps a 4-bit phase count that restarts at every cell-start change. A change seen at phases 5 to 11 counts as a mid-cell change.
- It presents each decoded bit on `rx_data`, followed by a rising edge of the recovered clock `rx_clk`.

If no change arrives for 24 sample periods, the receiver raises `clk_fail` and drops its cell alignment. The next change clears the flag and becomes the new alignment point. Framing, bit stuffing, CRC and line drivers belong to neighbouring blocks.

Top module: `fm_line_codec`

## Requirements
- R1: After synchronous reset, `tx_line`, `rx_clk`, `rx_data` and `clk_fail` are 0, and `tx_cell_start` is 0 while `tx_en` is 0.
- R2: While `tx_en` is 1, the transmitter runs 16-cycle cells. The first cycle of each cell asserts `tx_cell_start` and samples `tx_data`, and `tx_line` toggles on the following edge.
- R3: In a cell whose sampled bit is 0, `tx_line` toggles a second time, 8 cycles after the cell-start toggle. A cell carrying 1 has no second toggle.
- R4: While `tx_en` is 0, the cell counter returns to the cell start, `tx_line` holds its level, and `tx_data` has no effect.
- R5: The received line passes through two synchroniser flops before edge detection. The first change after reset, or after a clock failure, only sets the cell alignment and yields no bit.
- R6: Once aligned, a change arriving 5 to 11 sample periods after the last cell-start change is a mid-cell change. Any other change is a cell start, and it restarts the phase count.
- R7: At each cell-start change, the receiver loads `rx_data` with the previous cell's bit (0 if a mid-cell change was seen, 1 otherwise) and drives `rx_clk` low. `rx_clk` rises exactly once per decoded bit, 4 cycles after `rx_data` was loaded, and `rx_data` changes only while `rx_clk` is low.
- R8: After 24 consecutive sample periods with no detected change, `clk_fail` rises and the alignment is dropped. The next detected change clears `clk_fail`.
- R9: A cell-start change is accepted when the cell is shortened or lengthened by up to 2 samples, that is, when it arrives at phase 14, 15, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz sample clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| tx_data | input | 1 | Serial transmit bit, sampled when `tx_cell_start` is high |
| tx_cell_start | output | 1 | High in the cycle that samples `tx_data` |
| tx_line | output | 1 | Modulated line waveform |
| rx_line | input | 1 | Received line waveform (asynchronous) |
| rx_clk | output | 1 | Recovered bit clock; data is valid at its rising edge |
| rx_data | output | 1 | Decoded bit |
| clk_fail | output | 1 | No line change for too long |

## Verification
The transmitter is looped back into the receiver with four bursts: all ones, all zeros, alternating bits and pseudo-random bits. All ones exercises the longest normal gap, which must not trip the failure flag. All zeros exercises the densest change pattern. Alternating and random bits separate real mid-cell decoding from a decoder that only follows the previous bit.

Hand-built waveforms then place mid-cell changes at the two ends of the phase window. They also use cells of 14, 15, 17 and 18 samples. These patterns tell a correct window and resynchronisation apart from an off-by-one in either. Idle stretches after reset and between bursts check when the failure flag rises and falls, and that no bit comes from the alignment change.

// File: rtl/fm_codec_pkg.sv
package fm_codec_pkg;

    localparam int unsigned CELL_SAMPLES_DEF = 16;
    localparam int unsigned MID_LO_DEF       = 5;
    localparam int unsigned MID_HI_DEF       = 11;
    localparam int unsigned FAIL_LIMIT_DEF   = 24;
    localparam int unsigned RISE_PHASE_DEF   = 4;
    localparam int unsigned SYNC_STAGES_DEF  = 2;

    typedef enum logic [1:0] {
        EDGE_NONE,
        EDGE_ALIGN,
        EDGE_MID,
        EDGE_CELL
    } edge_kind_e;

    typedef struct packed {
        logic aligned;
        logic mid_seen;
        logic bit_ready;
    } dec_flags_t;

    function automatic edge_kind_e classify_edge(
        input logic seen,
        input logic aligned,
        input logic failed,
        input logic in_window
    );
        if (!seen)
            return EDGE_NONE;
        if (!aligned || failed)
            return EDGE_ALIGN;
        if (in_window)
            return EDGE_MID;
        return EDGE_CELL;
    endfunction

endpackage

// File: rtl/fm_tx_modulator.sv
module fm_tx_modulator #(
    parameter int unsigned CELL_SAMPLES = fm_codec_pkg::CELL_SAMPLES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic data,
    output logic cell_start,
    output logic line
);
    localparam int unsigned CW = $clog2(CELL_SAMPLES);
    localparam logic [CW-1:0] LAST_POS = CW'(CELL_SAMPLES - 1);
    localparam logic [CW-1:0] HALF_POS = CW'(CELL_SAMPLES / 2);

    logic [CW-1:0] pos_q;
    logic          bit_q;
    logic          line_q;
    logic          half_tick;

    // bit strobe and half-cell strobe derived from the sample clock
    assign cell_start = en && (pos_q == '0);
    assign half_tick  = en && (pos_q == HALF_POS);
    assign line       = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            bit_q  <= 1'b1;
            line_q <= 1'b0;
        end else if (!en) begin
            pos_q <= '0;
        end else begin
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
            if (cell_start) begin
                line_q <= ~line_q;
                bit_q  <= data;
            end else if (half_tick && !bit_q) begin
                line_q <= ~line_q;
            end
        end
    end

endmodule

// File: rtl/fm_rx_sync.sv
module fm_rx_sync #(
    parameter int unsigned STAGES = fm_codec_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic change
);
    // STAGES synchroniser flops plus one history flop for the compare
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-1:0], line_in};
    end

    assign change = chain_q[STAGES] ^ chain_q[STAGES-1];

endmodule

// File: rtl/fm_rx_watchdog.sv
module fm_rx_watchdog #(
    parameter int unsigned FAIL_LIMIT = fm_codec_pkg::FAIL_LIMIT_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic change,
    output logic fail
);
    localparam int unsigned GW = $clog2(FAIL_LIMIT);
    localparam logic [GW-1:0] GAP_END = GW'(FAIL_LIMIT - 1);

    logic [GW-1:0] gap_q;
    logic          fail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            fail_q <= 1'b0;
        end else if (change) begin
            gap_q  <= '0;
            fail_q <= 1'b0;
        end else if (gap_q == GAP_END) begin
            fail_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign fail = fail_q;

endmodule

// File: rtl/fm_rx_decoder.sv
module fm_rx_decoder
    import fm_codec_pkg::*;
#(
    parameter int unsigned CELL_SAMPLES = CELL_SAMPLES_DEF,
    parameter int unsigned MID_LO       = MID_LO_DEF,
    parameter int unsigned MID_HI       = MID_HI_DEF,
    parameter int unsigned RISE_PHASE   = RISE_PHASE_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic change,
    input  logic failed,
    output logic rx_clk,
    output logic rx_data
);
    localparam int unsigned PW = $clog2(CELL_SAMPLES);
    localparam logic [PW-1:0] LAST_PH = PW'(CELL_SAMPLES - 1);
    localparam logic [PW-1:0] LO_PH   = PW'(MID_LO);
    localparam logic [PW-1:0] HI_PH   = PW'(MID_HI);
    localparam logic [PW-1:0] RISE_PH = PW'(RISE_PHASE);
    localparam logic [PW-1:0] ONE_PH  = PW'(1);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] phase_inc;
    dec_flags_t    flags_q;
    logic          clk_q;
    logic          data_q;
    logic          in_window;
    edge_kind_e    kind;

    assign in_window = (phase_q >= LO_PH) && (phase_q <= HI_PH);
    assign kind      = classify_edge(change, flags_q.aligned, failed, in_window);
    assign phase_inc = (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            flags_q <= '0;
            clk_q   <= 1'b0;
            data_q  <= 1'b0;
        end else begin
            unique case (kind)
                EDGE_ALIGN: begin
                    phase_q <= ONE_PH;
                    flags_q <= '{aligned: 1'b1, mid_seen: 1'b0, bit_ready: 1'b0};
                    clk_q   <= 1'b0;
                end
                EDGE_MID: begin
                    phase_q          <= phase_inc;
                    flags_q.mid_seen <= 1'b1;
                end
                EDGE_CELL: begin
                    phase_q <= ONE_PH;
                    data_q  <= ~flags_q.mid_seen;
                    flags_q <= '{aligned: 1'b1, mid_seen: 1'b0, bit_ready: 1'b1};
                    clk_q   <= 1'b0;
                end
                default: begin
                    phase_q <= phase_inc;
                    if (failed) begin
                        flags_q <= '0;
                        clk_q   <= 1'b0;
                    end else if (flags_q.bit_ready && phase_q == RISE_PH) begin
                        clk_q             <= 1'b1;
                        flags_q.bit_ready <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign rx_clk  = clk_q;
    assign rx_data = data_q;

endmodule

// File: rtl/fm_line_codec.sv
module fm_line_codec
    import fm_codec_pkg::*;
#(
    parameter int unsigned CELL_SAMPLES = CELL_SAMPLES_DEF,
    parameter int unsigned MID_LO       = MID_LO_DEF,
    parameter int unsigned MID_HI       = MID_HI_DEF,
    parameter int unsigned RISE_PHASE   = RISE_PHASE_DEF,
    parameter int unsigned FAIL_LIMIT   = FAIL_LIMIT_DEF,
    parameter int unsigned SYNC_STAGES  = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic tx_data,
    output logic tx_cell_start,
    output logic tx_line,
    input  logic rx_line,
    output logic rx_clk,
    output logic rx_data,
    output logic clk_fail
);
    logic line_change;

    fm_tx_modulator #(.CELL_SAMPLES(CELL_SAMPLES)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .en         (tx_en),
        .data       (tx_data),
        .cell_start (tx_cell_start),
        .line       (tx_line)
    );

    fm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .line_in (rx_line),
        .change  (line_change)
    );

    fm_rx_watchdog #(.FAIL_LIMIT(FAIL_LIMIT)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .change (line_change),
        .fail   (clk_fail)
    );

    fm_rx_decoder #(
        .CELL_SAMPLES (CELL_SAMPLES),
        .MID_LO       (MID_LO),
        .MID_HI       (MID_HI),
        .RISE_PHASE   (RISE_PHASE)
    ) u_dec (
        .clk     (clk),
        .rst     (rst),
        .change  (line_change),
        .failed  (clk_fail),
        .rx_clk  (rx_clk),
        .rx_data (rx_data)
    );

endmodule

// File: rtl/fm_line_codec_checker.sv
module fm_line_codec_checker #(
    parameter int unsigned FAIL_LIMIT = fm_codec_pkg::FAIL_LIMIT_DEF
) (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic tx_cell_start,
    input logic tx_line,
    input logic rx_line,
    input logic rx_clk,
    input logic rx_data,
    input logic clk_fail
);
    logic [7:0] quiet_q;
    logic       prev_rx_q;

    // cycles since the sampled receive line last changed
    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q   <= '0;
            prev_rx_q <= 1'b0;
        end else begin
            prev_rx_q <= rx_line;
            if (rx_line != prev_rx_q)
                quiet_q <= '0;
            else if (quiet_q != 8'hFF)
                quiet_q <= quiet_q + 1'b1;
        end
    end

    assert_line_still_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_line) |-> $past(tx_en));

    assert_cell_start_toggles_R2: assert property (@(posedge clk) disable iff (rst)
        tx_cell_start |=> !$stable(tx_line));

    assert_clock_rises_on_steady_data_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_clk) |-> $stable(rx_data));

    assert_data_moves_with_clock_low_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> !rx_clk);

    assert_fail_needs_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_fail) |-> (quiet_q >= 8'(FAIL_LIMIT)));

    assert_fail_clears_after_change_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_fail) |-> (quiet_q <= 8'd3));

endmodule

bind fm_line_codec fm_line_codec_checker #(.FAIL_LIMIT(FAIL_LIMIT)) u_checker (
    .clk           (clk),
    .rst           (rst),
    .tx_en         (tx_en),
    .tx_cell_start (tx_cell_start),
    .tx_line       (tx_line),
    .rx_line       (rx_line),
    .rx_clk        (rx_clk),
    .rx_data       (rx_data),
    .clk_fail      (clk_fail)
);

// File: tb/test_fm_line_codec.sv
module test_fm_line_codec;

    logic clk = 1'b0;
    logic rst;
    logic tx_en;
    logic tx_data;
    logic rx_drv;
    logic loop_mode;
    logic tx_cell_start;
    logic tx_line;
    logic rx_line;
    logic rx_clk;
    logic rx_data;
    logic clk_fail;

    assign rx_line = loop_mode ? tx_line : rx_drv;

    always #5 clk = ~clk;

    fm_line_codec i_fm_line_codec (
        .clk           (clk),
        .rst           (rst),
        .tx_en         (tx_en),
        .tx_data       (tx_data),
        .tx_cell_start (tx_cell_start),
        .tx_line       (tx_line),
        .rx_line       (rx_line),
        .rx_clk        (rx_clk),
        .rx_data       (rx_data),
        .clk_fail      (clk_fail)
    );

    int   compared   = 0;
    int   mismatched = 0;
    bit   done       = 1'b0;

    // behavioural reference state
    int   tx_pos;
    logic exp_line;
    logic exp_bit;
    logic exp_fail;
    logic last_rx;
    logic prev_rxclk;
    int   quiet_n;
    logic exp_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one sample clock: model the edge just passed, then compare
    task automatic cycle();
        @(negedge clk);
        if (tx_en) begin
            if (tx_pos == 0) begin
                exp_line = ~exp_line;
                exp_bit  = tx_data;
                exp_q.push_back(tx_data);
            end else if (tx_pos == 8 && !exp_bit) begin
                exp_line = ~exp_line;
            end
            tx_pos = (tx_pos + 1) % 16;
        end else begin
            tx_pos = 0;
        end
        chk("R2 R3 R4 tx_line waveform", tx_line, exp_line);

        quiet_n++;
        if (quiet_n >= 27)
            exp_fail = 1'b1;
        else if (quiet_n >= 3)
            exp_fail = 1'b0;
        chk("R8 clk_fail", clk_fail, exp_fail);

        if (rx_clk && !prev_rxclk) begin
            if (exp_q.size() == 0) begin
                chk("R5 R7 unexpected rx_clk rise", 1, 0);
            end else begin
                chk("R6 R7 R9 decoded bit", rx_data, exp_q.pop_front());
            end
        end
        prev_rxclk = rx_clk;

        if (rx_line !== last_rx) begin
            quiet_n = 0;
            last_rx = rx_line;
        end
    endtask

    task automatic drive_tx(input logic en, input logic want);
        tx_en   = en;
        tx_data = (tx_pos == 0) ? want : logic'($urandom_range(0, 1));
        #1;
        chk("R2 tx_cell_start", tx_cell_start, (en && tx_pos == 0));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            drive_tx(1'b0, 1'b0);
            cycle();
        end
    endtask

    task automatic set_rx(input logic v);
        if (v !== rx_drv) begin
            rx_drv  = v;
            quiet_n = 0;
            last_rx = v;
        end
    endtask

    task automatic raw_cell(input logic b, input int len, input int mid_at);
        set_rx(~rx_drv);
        exp_q.push_back(b);
        cycle();
        for (int k = 1; k < len; k++) begin
            if (!b && k == mid_at)
                set_rx(~rx_drv);
            cycle();
        end
    endtask

    // kind: 0 ones, 1 zeros, 2 alternating, 3 random
    task automatic burst(input int kind, input int cells);
        for (int c = 0; c < cells; c++) begin
            logic b;
            case (kind)
                0:       b = 1'b1;
                1:       b = 1'b0;
                2:       b = logic'(c % 2);
                default: b = logic'($urandom_range(0, 1));
            endcase
            for (int s = 0; s < 16; s++) begin
                drive_tx(1'b1, b);
                cycle();
            end
        end
        idle(40);
        chk("R5 last open cell not decoded", exp_q.size(), 1);
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        tx_en     = 1'b0;
        tx_data   = 1'b0;
        rx_drv    = 1'b0;
        loop_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst        = 1'b0;
        tx_pos     = 0;
        exp_line   = 1'b0;
        exp_bit    = 1'b1;
        exp_fail   = 1'b0;
        last_rx    = 1'b0;
        prev_rxclk = 1'b0;
        quiet_n    = 3;

        // R1 reset state
        chk("R1 tx_line", tx_line, 0);
        chk("R1 rx_clk", rx_clk, 0);
        chk("R1 rx_data", rx_data, 0);
        chk("R1 clk_fail", clk_fail, 0);
        chk("R1 tx_cell_start", tx_cell_start, 0);

        // R4 and R8: disabled transmitter with toggling data, quiet line
        idle(30);

        loop_mode = 1'b1;
        burst(0, 6);
        burst(1, 6);
        burst(2, 8);
        burst(3, 20);

        rx_drv    = tx_line;
        last_rx   = tx_line;
        loop_mode = 1'b0;

        // R6 window ends, R9 cell length tolerance
        raw_cell(1'b1, 16, 0);
        raw_cell(1'b0, 16, 5);
        raw_cell(1'b0, 16, 11);
        raw_cell(1'b1, 14, 0);
        raw_cell(1'b0, 15, 8);
        raw_cell(1'b1, 17, 0);
        raw_cell(1'b0, 18, 6);
        raw_cell(1'b0, 16, 8);
        raw_cell(1'b1, 16, 0);
        set_rx(~rx_drv);
        cycle();
        idle(40);
        chk("R7 every closed cell decoded", exp_q.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule